// File: doc/BRIEF.md
# Interleaved Thread Subset Selector

This block picks, on every clock cycle, a group of four thread identifiers out of eight hardware threads and presents them to a downstream instruction-merge stage. The starting point is a window of four consecutive thread ids. Its base moves forward every cycle by a programmable step, wrapping modulo eight.

A thread in the window may be marked blocked, for example while it waits on a memory miss. The block then applies one of four replacement policies to that thread:
- Pass the window through with the blocked slot left unused.
- Substitute the next free thread.
- Substitute only the fixed partner thread four ids away, which shares the same cluster rotation.
- Try the partner first, then the next free thread.

A selected thread is only a candidate for merging. Whether its instruction issues is decided downstream.

The step and the mode are held in configuration registers that load from the inputs on every clock edge. A new value therefore acts one edge after it is captured. The blocked vector is used combinationally.

Top module: `thread_subset_sel`

## Requirements
- R1: While reset is asserted, the window base is thread 0, the registered step is 0 and the registered mode is static. With nothing blocked, the slots show threads 0,1,2,3, all valid.
- R2: On each clock edge the base advances by the registered step, modulo 8. `step_i` is captured into that register on the same edge, so a new step moves the base from the following edge on. A step of 0 freezes the window.
- R3: `mode_i` is encoded as 0 static, 1 first-free, 2 partner, 3 partner-then-first-free. It is captured on a clock edge, and outputs follow the new mode only after that edge.
- R4: In static mode, slot s carries thread (base+s) mod 8. Its valid bit is the inverse of that thread's blocked bit.
- R5: In first-free mode, a blocked window thread is replaced by the first thread, scanning upward from (base+4) mod 8 with wrap, that is unblocked, outside the window and not already chosen by a lower slot. If no such thread exists, the slot is invalid.
- R6: In partner mode, a blocked window thread t is replaced by thread (t+4) mod 8 if that thread is unblocked. Otherwise the slot is invalid.
- R7: In partner-then-first-free mode, the partner is tried first and the first-free scan of R5 is used only when the partner is blocked or already taken.
- R8: In every mode, an unblocked window thread keeps its own slot, valid, with its own id. Slots resolve in order 0 to 3. An invalid slot reports its window thread id.
- R9: No valid slot carries a blocked thread, and no thread id appears in two valid slots.
- R10: When all eight threads are blocked, all four valid bits are low in every mode.
- R11: Slot s occupies bit s of `slot_vld_o` and bits [3s+2:3s] of `slot_tid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blocked_i | input | 8 | Bit t high means thread t is blocked |
| mode_i | input | 2 | Replacement policy, captured each edge |
| step_i | input | 3 | Interleaving step, captured each edge |
| slot_vld_o | output | 4 | Per-slot valid |
| slot_tid_o | output | 12 | Per-slot thread id, 3 bits per slot |

## Verification
The assertions take for granted that the blocked vector is a full 8-bit mask that is known on every sampled edge. They also assume the thread count is a power of two, so that the base register wraps on its own. Apart from those assumptions, they constrain neither mode nor step: any encoding is legal.

The stimulus changes inputs only on falling edges and holds reset for two cycles before each vector. The captured mode and step are therefore always defined when the checked edges arrive. The blocked patterns are chosen to reach each replacement branch, including a scan that wraps, a scan that runs dry, and a fully blocked machine.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    SEL_STATIC  = 2'd0,
    SEL_FNB     = 2'd1,
    SEL_EQV     = 2'd2,
    SEL_EQV_FNB = 2'd3
  } sel_mode_e;
endpackage

// File: rtl/tss_window.sv
module tss_window
  import tss_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int TID_W = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] step_i,
  input  sel_mode_e        mode_i,
  output logic [TID_W-1:0] base_o,
  output sel_mode_e        mode_o
);
  logic [TID_W-1:0] base_q, step_q;
  sel_mode_e        mode_q;

  // base wraps naturally because NTHR is a power of two
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      mode_q <= SEL_STATIC;
    end else begin
      step_q <= step_i;
      mode_q <= mode_i;
      base_q <= base_q + step_q;
    end
  end

  assign base_o = base_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/tss_slot.sv
module tss_slot
  import tss_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NSLOT = 4,
  parameter int TID_W = $clog2(NTHR)
) (
  input  sel_mode_e        mode_i,
  input  logic [TID_W-1:0] base_i,
  input  logic [TID_W-1:0] own_i,
  input  logic [NTHR-1:0]  blocked_i,
  input  logic [NTHR-1:0]  taken_i,
  output logic             vld_o,
  output logic [TID_W-1:0] tid_o,
  output logic [NTHR-1:0]  taken_o
);
  localparam int HALF = NTHR / 2;

  logic [TID_W-1:0] partner, scan_tid, cand;
  logic             partner_ok, scan_ok;

  assign partner    = own_i + TID_W'(HALF);
  assign partner_ok = !blocked_i[partner] && !taken_i[partner];

  // first free thread, upward from the one just past the window
  always_comb begin
    scan_ok  = 1'b0;
    scan_tid = own_i;
    cand     = '0;
    for (int k = 0; k < NTHR; k++) begin
      cand = base_i + TID_W'(NSLOT) + TID_W'(k);
      if (!scan_ok && !blocked_i[cand] && !taken_i[cand]) begin
        scan_ok  = 1'b1;
        scan_tid = cand;
      end
    end
  end

  always_comb begin
    vld_o = 1'b0;
    tid_o = own_i;
    if (!blocked_i[own_i]) begin
      vld_o = 1'b1;
    end else begin
      unique case (mode_i)
        SEL_STATIC: ;
        SEL_FNB: begin
          vld_o = scan_ok;
          if (scan_ok) tid_o = scan_tid;
        end
        SEL_EQV: begin
          vld_o = partner_ok;
          if (partner_ok) tid_o = partner;
        end
        SEL_EQV_FNB: begin
          if (partner_ok) begin
            vld_o = 1'b1;
            tid_o = partner;
          end else if (scan_ok) begin
            vld_o = 1'b1;
            tid_o = scan_tid;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    taken_o = taken_i;
    if (vld_o) taken_o[tid_o] = 1'b1;
  end
endmodule

// File: rtl/thread_subset_sel.sv
module thread_subset_sel
  import tss_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NSLOT = 4,
  parameter int TID_W = $clog2(NTHR)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NTHR-1:0]        blocked_i,
  input  logic [1:0]             mode_i,
  input  logic [TID_W-1:0]       step_i,
  output logic [NSLOT-1:0]       slot_vld_o,
  output logic [NSLOT*TID_W-1:0] slot_tid_o
);
  logic [TID_W-1:0] base;
  sel_mode_e        mode_q;
  logic [NTHR-1:0]  win_mask;
  logic [NTHR-1:0]  taken [NSLOT+1];
  logic [TID_W-1:0] own [NSLOT];

  tss_window #(.NTHR(NTHR), .TID_W(TID_W)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_i),
    .mode_i (sel_mode_e'(mode_i)),
    .base_o (base),
    .mode_o (mode_q)
  );

  always_comb begin
    win_mask = '0;
    for (int s = 0; s < NSLOT; s++) win_mask[TID_W'(base + TID_W'(s))] = 1'b1;
  end

  assign taken[0] = win_mask;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign own[s] = base + TID_W'(s);

    tss_slot #(.NTHR(NTHR), .NSLOT(NSLOT), .TID_W(TID_W)) u_slot (
      .mode_i    (mode_q),
      .base_i    (base),
      .own_i     (own[s]),
      .blocked_i (blocked_i),
      .taken_i   (taken[s]),
      .vld_o     (slot_vld_o[s]),
      .tid_o     (slot_tid_o[s*TID_W +: TID_W]),
      .taken_o   (taken[s+1])
    );

    // R8
    keep_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !blocked_i[own[s]] |-> (slot_vld_o[s] && slot_tid_o[s*TID_W +: TID_W] == own[s]));

    // R6
    eqv_partner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == SEL_EQV && slot_vld_o[s]) |->
        (slot_tid_o[s*TID_W +: TID_W] == own[s] ||
         slot_tid_o[s*TID_W +: TID_W] == TID_W'(own[s] + TID_W'(NTHR/2))));

    if (s > 0) begin : g_adj
      // R4
      static_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == SEL_STATIC |->
          slot_tid_o[s*TID_W +: TID_W] == TID_W'(slot_tid_o[(s-1)*TID_W +: TID_W] + 1'b1));
    end
  end

  // one-hot view of the valid picks, rebuilt from the outputs
  logic [NTHR-1:0] pick_mask;
  always_comb begin
    pick_mask = '0;
    for (int s = 0; s < NSLOT; s++)
      if (slot_vld_o[s]) pick_mask[slot_tid_o[s*TID_W +: TID_W]] = 1'b1;
  end

  // R9
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pick_mask) == $countones(slot_vld_o));

  // R9
  no_blocked_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_mask & blocked_i) == '0);

  // R10
  all_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&blocked_i) |-> (slot_vld_o == '0));
endmodule

// File: tb/tb_thread_subset_sel.sv
module tb_thread_subset_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  blocked_i;
  logic [1:0]  mode_i;
  logic [2:0]  step_i;
  logic [3:0]  slot_vld_o;
  logic [11:0] slot_tid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  thread_subset_sel dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .blocked_i  (blocked_i),
    .mode_i     (mode_i),
    .step_i     (step_i),
    .slot_vld_o (slot_vld_o),
    .slot_tid_o (slot_tid_o)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [1:0] mode;
    logic [2:0] step;
    logic [7:0] blk;
    logic [2:0] k;
    logic [3:0] vld;
    logic [2:0] t3, t2, t1, t0;
  } vec_t;

  localparam int NV = 16;
  // k = extra edges after the configuration edge; base = k*step mod 8
  localparam vec_t VECS [NV] = '{
    '{4'd4,  2'd0, 3'd0, 8'h00, 3'd0, 4'hF, 3'd3, 3'd2, 3'd1, 3'd0}, // R4 plain
    '{4'd4,  2'd0, 3'd0, 8'h06, 3'd0, 4'h9, 3'd3, 3'd2, 3'd1, 3'd0}, // R4 wasted slots
    '{4'd5,  2'd1, 3'd0, 8'h06, 3'd0, 4'hF, 3'd3, 3'd5, 3'd4, 3'd0}, // R5
    '{4'd6,  2'd2, 3'd0, 8'h46, 3'd0, 4'hB, 3'd3, 3'd2, 3'd5, 3'd0}, // R6 partner blocked
    '{4'd7,  2'd3, 3'd0, 8'h46, 3'd0, 4'hF, 3'd3, 3'd4, 3'd5, 3'd0}, // R7
    '{4'd2,  2'd0, 3'd1, 8'h00, 3'd1, 4'hF, 3'd4, 3'd3, 3'd2, 3'd1}, // R2 step 1
    '{4'd2,  2'd0, 3'd2, 8'h00, 3'd2, 4'hF, 3'd7, 3'd6, 3'd5, 3'd4}, // R2 step 2
    '{4'd2,  2'd0, 3'd2, 8'h00, 3'd3, 4'hF, 3'd1, 3'd0, 3'd7, 3'd6}, // R2 wrap
    '{4'd2,  2'd0, 3'd7, 8'h00, 3'd1, 4'hF, 3'd2, 3'd1, 3'd0, 3'd7}, // R2 step 7
    '{4'd10, 2'd1, 3'd0, 8'hFF, 3'd0, 4'h0, 3'd3, 3'd2, 3'd1, 3'd0}, // R10 first-free
    '{4'd10, 2'd3, 3'd0, 8'hFF, 3'd0, 4'h0, 3'd3, 3'd2, 3'd1, 3'd0}, // R10 combined
    '{4'd5,  2'd1, 3'd2, 8'h61, 3'd2, 4'hF, 3'd7, 3'd2, 3'd1, 3'd4}, // R5 scan wraps
    '{4'd5,  2'd1, 3'd0, 8'h77, 3'd0, 4'h9, 3'd3, 3'd2, 3'd1, 3'd7}, // R5 scan runs dry
    '{4'd7,  2'd3, 3'd0, 8'h11, 3'd0, 4'hF, 3'd3, 3'd2, 3'd1, 3'd5}, // R7 fallback
    '{4'd6,  2'd2, 3'd0, 8'h01, 3'd0, 4'hF, 3'd3, 3'd2, 3'd1, 3'd4}, // R6 partner used
    '{4'd7,  2'd3, 3'd0, 8'h02, 3'd0, 4'hF, 3'd3, 3'd2, 3'd5, 3'd0}  // R7 partner first
  };

  task automatic check(input string req, input logic [3:0] ev, input logic [11:0] et);
    n_chk++;
    if (slot_vld_o !== ev || slot_tid_o !== et) begin
      n_bad++;
      $display("FAIL %s: vld=%b tid=%h expected vld=%b tid=%h", req, slot_vld_o, slot_tid_o, ev, et);
    end
  endtask

  task automatic start(input logic [1:0] m, input logic [2:0] st, input logic [7:0] b);
    @(negedge clk);
    rst_n = 1'b0; mode_i = m; step_i = st; blocked_i = b;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_i = 2'd1; step_i = 3'd5; blocked_i = 8'h00;
    repeat (2) @(negedge clk);
    // R1 and R11: reset window 0..3, slot s in bits [3s+2:3s]
    check("R1", 4'hF, {3'd3, 3'd2, 3'd1, 3'd0});

    for (int i = 0; i < NV; i++) begin
      start(VECS[i].mode, VECS[i].step, VECS[i].blk);
      repeat (int'(VECS[i].k)) @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].vld,
            {VECS[i].t3, VECS[i].t2, VECS[i].t1, VECS[i].t0});
    end

    // R3: mode change is seen only after the next edge
    start(2'd1, 3'd0, 8'h06);
    @(negedge clk);
    mode_i = 2'd0;
    #2 check("R3 old mode held", 4'hF, {3'd3, 3'd5, 3'd4, 3'd0});
    @(negedge clk);
    check("R3 new mode", 4'h9, {3'd3, 3'd2, 3'd1, 3'd0});

    // R2: step change delays one edge before moving the base
    start(2'd0, 3'd0, 8'h00);
    @(negedge clk);
    step_i = 3'd3;
    @(negedge clk);
    check("R2 step capture", 4'hF, {3'd3, 3'd2, 3'd1, 3'd0});
    step_i = 3'd0;
    @(negedge clk);
    check("R2 step applied", 4'hF, {3'd6, 3'd5, 3'd4, 3'd3});
    @(negedge clk);
    check("R2 step zero freeze", 4'hF, {3'd6, 3'd5, 3'd4, 3'd3});

    // R8: unblocked threads stay put under partner mode
    start(2'd2, 3'd0, 8'h80);
    @(negedge clk);
    check("R8", 4'hF, {3'd3, 3'd2, 3'd1, 3'd0});

    finish_run();
  end
endmodule